// File: doc/BRIEF.md
# Per-Queue Token-Bucket Transmit Shaper

This block limits the transmit rate of up to eight queues, each with its own token bucket counted in bits. One prescaler divides the core clock into a base tick. Each queue counts base ticks up to its own refill period. When that count completes, the queue adds its refill amount to its bucket, and the bucket never goes above its programmed size. With a 100 ns base tick and a refill period of 1000, one unit of refill amount is worth 10 kbit/s. The 19-bit amount therefore covers rates from 10 kbit/s to about 5 Gbit/s.

A scheduler outside the block presents one request at a time: a queue number and a frame length in bytes. One cycle later the block raises `grant` if the queue holds at least eight tokens per byte, and the cost is taken from the bucket on that same edge. Software programs the block through a write-only register port. A command register turns shaping on only when both of its control bits are zero. While shaping is off, every request passes and the buckets stay as they are. A level port lets the caller read back any bucket.

Top module: `txs_shaper`

## Requirements
- R1: Reset sets both command bits, so shaping is off. Every bucket and every size register holds 0x7FFFFFFF. The prescaler and period counters read zero, and `grant` and `lvl_data` read 0.
- R2: The command register sits at byte address 0x00. Bit 0 is the limiter-disable bit and bit 3 is the legacy-select bit. Shaping is on exactly when both bits are 0. `shaping_on` shows this state starting the cycle after the write.
- R3: The bucket-size register of queue q sits at 0x40+4q and takes data bits 30:0. Writing it sets both the size and the bucket to the value written. A bucket never exceeds its size.
- R4: The prescaler register sits at 0x04 and takes bits 15:0. While shaping is on, one base tick occurs every max(value,1) core cycles.
- R5: The refill register of queue q sits at 0x20+4q. The period is in bits 29:20 and the amount in bits 18:0. While shaping is on, every max(period,1) base ticks the amount is added to the bucket, and the result is limited to the size.
- R6: A request with `req_valid`, `req_queue` and `req_len` (bytes) gets `grant` high one cycle later, for one cycle, when shaping is on only if the bucket holds at least 8*req_len. On a grant, 8*req_len is subtracted on the same edge. Otherwise the bucket is unchanged.
- R7: While shaping is off, every request is granted. Buckets do not change except by size writes, and all counters are held at zero.
- R8: When a refill and a granted deduction fall on the same edge, the new bucket is min(bucket + amount - cost, size).
- R9: `lvl_data` shows, one cycle later, the bucket of queue `lvl_sel` as it stood before that edge.
- R10: Writes to unmapped addresses have no effect. Command bits other than 0 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Transmit request present |
| req_queue | input | 3 | Queue of the request |
| req_len | input | 16 | Frame length in bytes |
| lvl_sel | input | 3 | Queue whose bucket is read back |
| grant | output | 1 | One-cycle grant for the previous cycle's request |
| shaping_on | output | 1 | Shaping currently active |
| lvl_data | output | 31 | Bucket level of the selected queue |

## Verification
The hardest case to reach is a refill event that lands on the same edge as a granted deduction, and in particular the case where the sum must then be clamped to the size. The stimulus sets the prescaler and the refill period both to one, so a refill occurs on every edge, and then holds requests back to back on that queue. With a large amount the bucket stays pinned at its size. With a small amount it drains by the difference on each edge. After that, a long random phase mixes requests across all queues with commands that switch shaping off and on, and a behavioural model follows it on every cycle.

// File: rtl/txs_pkg.sv
package txs_pkg;
  // Register map (byte addresses)
  localparam int ADDR_CMD         = 'h00;
  localparam int ADDR_PRESC       = 'h04;
  localparam int ADDR_REFILL_BASE = 'h20;
  localparam int ADDR_SIZE_BASE   = 'h40;
  // Command bit positions
  localparam int CMD_DIS_BIT      = 0;
  localparam int CMD_LEGACY_BIT   = 3;
  // Refill register field placement
  localparam int REFILL_PER_LSB   = 20;
  localparam int REFILL_AMT_LSB   = 0;
endpackage

// File: rtl/txs_regs.sv
module txs_regs
  import txs_pkg::*;
#(
  parameter int NQ        = 8,
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int PW        = 16,
  parameter int PERW      = 10,
  parameter int AMTW      = 19,
  parameter int BW        = 31,
  parameter logic [PW-1:0] PRESC_RST = PW'(10),
  parameter logic [BW-1:0] BKT_RST   = {BW{1'b1}}
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [AW-1:0]             addr,
  input  logic [DW-1:0]             wdata,
  output logic                      shaping_on,
  output logic [PW-1:0]             presc,
  output logic [NQ-1:0][PERW-1:0]   period,
  output logic [NQ-1:0][AMTW-1:0]   amount,
  output logic [NQ-1:0][BW-1:0]     size,
  output logic [NQ-1:0]             size_wr,
  output logic [BW-1:0]             size_val
);
  logic dis_q;
  logic legacy_q;

  wire hit_cmd   = we && (addr == AW'(ADDR_CMD));
  wire hit_presc = we && (addr == AW'(ADDR_PRESC));

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_q    <= 1'b1;
      legacy_q <= 1'b1;
      presc    <= PRESC_RST;
    end else begin
      if (hit_cmd) begin
        dis_q    <= wdata[CMD_DIS_BIT];
        legacy_q <= wdata[CMD_LEGACY_BIT];
      end
      if (hit_presc) presc <= wdata[PW-1:0];
    end
  end

  assign shaping_on = !dis_q && !legacy_q;
  assign size_val   = wdata[BW-1:0];

  for (genvar q = 0; q < NQ; q++) begin : g_q
    wire hit_refill = we && (addr == AW'(ADDR_REFILL_BASE + 4*q));
    assign size_wr[q] = we && (addr == AW'(ADDR_SIZE_BASE + 4*q));

    always_ff @(posedge clk) begin
      if (rst) begin
        period[q] <= '0;
        amount[q] <= '0;
        size[q]   <= BKT_RST;
      end else begin
        if (hit_refill) begin
          period[q] <= wdata[REFILL_PER_LSB +: PERW];
          amount[q] <= wdata[REFILL_AMT_LSB +: AMTW];
        end
        if (size_wr[q]) size[q] <= wdata[BW-1:0];
      end
    end
  end
endmodule

// File: rtl/txs_prescale.sv
module txs_prescale #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [PW-1:0] presc,
  output logic          tick
);
  logic [PW-1:0] cnt;
  wire  [PW:0]   cnt_nx = {1'b0, cnt} + (PW+1)'(1);

  assign tick = run && (cnt_nx >= {1'b0, presc});

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt_nx[PW-1:0];
  end
endmodule

// File: rtl/txs_bucket.sv
module txs_bucket #(
  parameter int PERW = 10,
  parameter int AMTW = 19,
  parameter int BW   = 31,
  parameter int CW   = 19,
  parameter logic [BW-1:0] BKT_RST = {BW{1'b1}}
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            tick,
  input  logic [PERW-1:0] period,
  input  logic [AMTW-1:0] amount,
  input  logic [BW-1:0]   size,
  input  logic            size_wr,
  input  logic [BW-1:0]   size_val,
  input  logic            req_hit,
  input  logic [CW-1:0]   cost,
  output logic [BW-1:0]   level,
  output logic            take
);
  localparam int SW = BW + 2;

  logic [PERW-1:0] pcnt;
  wire  [PERW:0]   pcnt_nx = {1'b0, pcnt} + (PERW+1)'(1);
  wire             evt     = tick && (pcnt_nx >= {1'b0, period});

  logic [SW-1:0] sum;
  logic [BW-1:0] nxt;

  assign take = run && req_hit && ({{(SW-BW){1'b0}}, level} >= SW'(cost));

  always_comb begin
    sum = {{(SW-BW){1'b0}}, level};
    if (evt)  sum = sum + SW'(amount);
    if (take) sum = sum - SW'(cost);
    if (sum > {{(SW-BW){1'b0}}, size}) nxt = size;
    else                               nxt = sum[BW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || !run) pcnt <= '0;
    else if (evt)    pcnt <= '0;
    else if (tick)   pcnt <= pcnt_nx[PERW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)          level <= BKT_RST;
    else if (size_wr) level <= size_val;
    else if (run)     level <= nxt;
  end
endmodule

// File: rtl/txs_shaper.sv
module txs_shaper #(
  parameter int NQ   = 8,
  parameter int AW   = 8,
  parameter int DW   = 32,
  parameter int PW   = 16,
  parameter int PERW = 10,
  parameter int AMTW = 19,
  parameter int BW   = 31,
  parameter int LW   = 16,
  parameter logic [PW-1:0] PRESC_RST = PW'(10),
  parameter logic [BW-1:0] BKT_RST   = {BW{1'b1}},
  localparam int QW  = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int CW  = LW + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          req_valid,
  input  logic [QW-1:0] req_queue,
  input  logic [LW-1:0] req_len,
  input  logic [QW-1:0] lvl_sel,
  output logic          grant,
  output logic          shaping_on,
  output logic [BW-1:0] lvl_data
);
  logic [PW-1:0]           presc;
  logic [NQ-1:0][PERW-1:0] period;
  logic [NQ-1:0][AMTW-1:0] amount;
  logic [NQ-1:0][BW-1:0]   size;
  logic [NQ-1:0]           size_wr;
  logic [BW-1:0]           size_val;
  logic                    tick;
  logic [NQ-1:0][BW-1:0]   level;
  logic [NQ-1:0]           take;

  wire [CW-1:0] cost = {req_len, 3'b000};

  txs_regs #(
    .NQ(NQ), .AW(AW), .DW(DW), .PW(PW), .PERW(PERW), .AMTW(AMTW), .BW(BW),
    .PRESC_RST(PRESC_RST), .BKT_RST(BKT_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .shaping_on(shaping_on), .presc(presc), .period(period), .amount(amount),
    .size(size), .size_wr(size_wr), .size_val(size_val)
  );

  txs_prescale #(.PW(PW)) u_presc (
    .clk(clk), .rst(rst), .run(shaping_on), .presc(presc), .tick(tick)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_bkt
    txs_bucket #(
      .PERW(PERW), .AMTW(AMTW), .BW(BW), .CW(CW), .BKT_RST(BKT_RST)
    ) u_bkt (
      .clk(clk), .rst(rst), .run(shaping_on), .tick(tick),
      .period(period[q]), .amount(amount[q]), .size(size[q]),
      .size_wr(size_wr[q]), .size_val(size_val),
      .req_hit(req_valid && (req_queue == QW'(q))), .cost(cost),
      .level(level[q]), .take(take[q])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant    <= 1'b0;
      lvl_data <= '0;
    end else begin
      grant    <= req_valid && (!shaping_on || take[req_queue]);
      lvl_data <= level[lvl_sel];
    end
  end
endmodule

// File: rtl/txs_chk.sv
module txs_chk #(
  parameter int NQ = 8,
  parameter int BW = 31
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic                  grant,
  input logic                  shaping_on,
  input logic [NQ-1:0][BW-1:0] level,
  input logic [NQ-1:0][BW-1:0] size
);
  AST_RESET_OFF: assert property (@(posedge clk) $past(rst) |-> !shaping_on); // R1
  AST_GRANT_CAUSE: assert property (@(posedge clk) disable iff (rst) grant |-> $past(req_valid)); // R6
  AST_OFF_PASSES: assert property (@(posedge clk) disable iff (rst) (req_valid && !shaping_on) |=> grant); // R7

  for (genvar q = 0; q < NQ; q++) begin : g_cap
    AST_BKT_CAP: assert property (@(posedge clk) disable iff (rst) level[q] <= size[q]); // R3
  end
endmodule

bind txs_shaper txs_chk #(.NQ(NQ), .BW(BW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .grant(grant),
  .shaping_on(shaping_on), .level(level), .size(size)
);

// File: tb/tb_txs_shaper.sv
module tb_txs_shaper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_queue = '0;
  logic [15:0] req_len = '0;
  logic [2:0]  lvl_sel = '0;
  logic        grant;
  logic        shaping_on;
  logic [30:0] lvl_data;

  always #5 clk = ~clk;

  txs_shaper dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_queue(req_queue),
    .req_len(req_len), .lvl_sel(lvl_sel), .grant(grant),
    .shaping_on(shaping_on), .lvl_data(lvl_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Behavioural reference model
  longint m_bk[8], m_sz[8], m_amt[8], m_per[8], m_qc[8];
  longint m_pc, m_presc, m_lvl;
  bit     m_dis, m_leg, m_gnt;

  always @(posedge clk) begin : model
    bit on, tick, ev, tk;
    longint nb, cost, a;
    cyc++;
    if (rst) begin
      m_dis = 1; m_leg = 1; m_presc = 10; m_pc = 0; m_gnt = 0; m_lvl = 0;
      for (int q = 0; q < 8; q++) begin
        m_bk[q] = 64'h7FFFFFFF; m_sz[q] = 64'h7FFFFFFF;
        m_amt[q] = 0; m_per[q] = 0; m_qc[q] = 0;
      end
    end else begin
      on   = !m_dis && !m_leg;
      cost = 8 * longint'(req_len);
      m_gnt = req_valid && (!on || m_bk[req_queue] >= cost);
      m_lvl = m_bk[lvl_sel];
      if (on) begin
        tick = (m_pc + 1 >= m_presc);
        m_pc = tick ? 0 : m_pc + 1;
        for (int q = 0; q < 8; q++) begin
          ev = tick && (m_qc[q] + 1 >= m_per[q]);
          if (ev) m_qc[q] = 0; else if (tick) m_qc[q]++;
          tk = req_valid && (req_queue == q) && (m_bk[q] >= cost);
          nb = m_bk[q] + (ev ? m_amt[q] : 0) - (tk ? cost : 0);
          m_bk[q] = (nb > m_sz[q]) ? m_sz[q] : nb;
        end
      end else begin
        m_pc = 0;
        for (int q = 0; q < 8; q++) m_qc[q] = 0;
      end
      if (cfg_we) begin
        a = cfg_addr;
        if (a == 0) begin m_dis = cfg_wdata[0]; m_leg = cfg_wdata[3]; end
        else if (a == 4) m_presc = cfg_wdata[15:0];
        else if (a >= 'h20 && a < 'h40 && a % 4 == 0) begin
          m_per[(a - 'h20) / 4] = cfg_wdata[29:20];
          m_amt[(a - 'h20) / 4] = cfg_wdata[18:0];
        end else if (a >= 'h40 && a < 'h60 && a % 4 == 0) begin
          m_sz[(a - 'h40) / 4] = cfg_wdata[30:0];
          m_bk[(a - 'h40) / 4] = cfg_wdata[30:0];
        end
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(grant == m_gnt, "R6 R7 grant", grant, m_gnt);
      chk(lvl_data == m_lvl[30:0], "R9 R5 R8 level", lvl_data, m_lvl);
    end
  end

  initial begin : watchdog
    wait (cyc > 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(input int q, output longint v);
    @(negedge clk);
    lvl_sel = 3'(q);
    @(negedge clk);
    v = lvl_data;
  endtask

  task automatic req(input int q, input int len, output bit g);
    @(negedge clk);
    req_valid = 1; req_queue = 3'(q); req_len = 16'(len);
    @(negedge clk);
    req_valid = 0;
    g = grant;
  endtask

  initial begin : main
    longint v;
    bit g;
    repeat (5) @(negedge clk);
    rst = 0;

    // R1: reset state
    chk(shaping_on == 0, "R1 shaping off", shaping_on, 0);
    chk(grant == 0, "R1 grant low", grant, 0);
    for (int q = 0; q < 8; q++) begin
      rd(q, v);
      chk(v == 64'h7FFFFFFF, "R1 bucket full", v, 64'h7FFFFFFF);
    end

    // R3: size write loads bucket
    wr(8'h48, 32'd500);
    rd(2, v);
    chk(v == 500, "R3 size load", v, 500);

    // R2: enable shaping
    wr(8'h00, 32'h0);
    chk(shaping_on == 1, "R2 enable", shaping_on, 1);

    // R6: insufficient tokens then sufficient
    req(2, 100, g);
    chk(g == 0, "R6 deny", g, 0);
    rd(2, v);
    chk(v == 500, "R6 deny keeps bucket", v, 500);
    req(2, 50, g);
    chk(g == 1, "R6 grant", g, 1);
    rd(2, v);
    chk(v == 100, "R6 deduct", v, 100);

    // R10: unmapped write and extra command bits
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h62, 32'h0000_0005);
    wr(8'h00, 32'hFFFF_FFF6);
    chk(shaping_on == 1, "R10 other cmd bits", shaping_on, 1);
    rd(2, v);
    chk(v == 100, "R10 unmapped ignored", v, 100);

    // R2/R7: either bit alone turns shaping off
    wr(8'h00, 32'h1);
    chk(shaping_on == 0, "R2 disable bit", shaping_on, 0);
    req(2, 1000, g);
    chk(g == 1, "R7 pass when off", g, 1);
    rd(2, v);
    chk(v == 100, "R7 bucket untouched", v, 100);
    wr(8'h00, 32'h8);
    chk(shaping_on == 0, "R2 legacy bit", shaping_on, 0);
    wr(8'h00, 32'h0);

    // R4/R5: refill through prescaler and period
    wr(8'h04, 32'd3);
    wr(8'h28, (32'd2 << 20) | 32'd7);
    repeat (60) @(negedge clk);
    rd(2, v);
    chk(v > 100 && (v - 100) % 7 == 0, "R4 R5 refill growth", v, 100);

    // R8: refill and deduction on every edge, clamped at size
    wr(8'h04, 32'd1);
    wr(8'h54, 32'd100);
    wr(8'h34, (32'd1 << 20) | 32'd50);
    @(negedge clk);
    req_valid = 1; req_queue = 3'd5; req_len = 16'd1; lvl_sel = 3'd5;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(grant == 1, "R8 back-to-back grant", grant, 1);
    end
    req_valid = 0;
    rd(5, v);
    chk(v == 100, "R8 clamp at size", v, 100);

    // R8: net drain when amount below cost
    wr(8'h58, 32'd100);
    wr(8'h38, (32'd1 << 20) | 32'd5);
    @(negedge clk);
    req_valid = 1; req_queue = 3'd6; req_len = 16'd1; lvl_sel = 3'd6;
    repeat (10) @(negedge clk);
    req_valid = 0;
    chk(lvl_data == 73, "R8 net drain", lvl_data, 73);

    // Random mixed phase against the model
    for (int q = 0; q < 8; q++) begin
      wr(8'(8'h40 + 4*q), 32'(200 + 50*q));
      wr(8'(8'h20 + 4*q), (32'(q % 4 + 1) << 20) | 32'(q + 3));
    end
    wr(8'h04, 32'd2);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      req_valid = 1'($urandom % 2);
      req_queue = 3'($urandom % 8);
      req_len   = 16'($urandom % 40);
      lvl_sel   = 3'($urandom % 8);
      if ($urandom % 150 == 0) begin
        cfg_we = 1; cfg_addr = 8'h00; cfg_wdata = 32'($urandom % 2);
      end else cfg_we = 0;
    end
    cfg_we = 0; req_valid = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule